// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block is a small first-in first-out store for code bytes that a bus side fetches ahead of execution. The bus side delivers either a whole 16-bit word or, when the fetch offset is odd, one byte. An execution side takes bytes one at a time from the head. Fetching and consuming may happen in the same cycle, so fetch overlaps execution.

The block keeps the code fetch offset itself. A word fill moves the offset on by two and a single-byte fill moves it on by one. It raises `fetch_req` whenever there is room for the next fetch. When control flow changes, a flush empties the queue in one cycle and loads a new offset. Each cycle a two-bit status code tells an outside observer what the queue did on the previous clock edge: nothing, first opcode byte taken, later byte taken, or flush. From that code the observer can follow instruction boundaries.

Top module: `prefetch_queue`

## Requirements
- R1: Bytes leave in the order they were filled. While `head_valid` is 1, `head_byte` shows the oldest stored byte, and an accepted `pop` removes it.
- R2: The queue holds at most DEPTH (default 6) bytes. `fetch_req` is 1 exactly when at least two entries are free, or when one entry is free and `fetch_ofs` is odd.
- R3: An accepted fill at an even offset stores `fill_data[7:0]` and then `fill_data[15:8]`, and adds 2 to `fetch_ofs`. At an odd offset it stores only `fill_data[15:8]` and adds 1.
- R4: `qstat` after a clock edge reports that edge's operation: 2'b01 when a byte was popped with `pop_first`=1, 2'b11 when a byte was popped with `pop_first`=0, and 2'b00 when no byte was taken.
- R5: A flush empties the queue, loads `fetch_ofs` from `flush_ofs` and gives `qstat` = 2'b10 on the next cycle. In that cycle it overrides any fill and any pop.
- R6: A pop while the queue is empty is ignored: the queue stays empty, `qstat` is 2'b00, and `underflow` is 1 for the following cycle only.
- R7: A fill and a pop in the same cycle both take effect. Room for the fill is judged on the occupancy before the pop.
- R8: After reset the queue is empty, `fetch_ofs` equals RESET_OFS (default 0), `qstat` is 2'b00 and `underflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_valid | input | 1 | Fetched code is present on `fill_data` this cycle |
| fill_data | input | 16 | Fetched word; lower byte at the even address |
| fetch_req | output | 1 | Room for the next fetch at `fetch_ofs` |
| fetch_ofs | output | 16 | Offset of the next code fetch |
| pop | input | 1 | Take the head byte |
| pop_first | input | 1 | The popped byte is the first byte of an opcode |
| head_valid | output | 1 | Queue is not empty |
| head_byte | output | 8 | Oldest stored byte |
| flush | input | 1 | Empty the queue and restart fetching |
| flush_ofs | input | 16 | New fetch offset loaded on flush |
| qstat | output | 2 | Operation status of the previous edge |
| underflow | output | 1 | Pulse after a pop on an empty queue |

## Verification
The assertions assume that the bus side raises `fill_valid` only in cycles where `fetch_req` is 1. With that assumption the occupancy bound and the offset stepping are properties of the design and not of the stimulus. The bench follows the rule by computing the room from its own model and driving a fill only when that model grants it. Pops are not restricted, so empty-queue pops are driven on purpose, and so are flushes together with fills and pops.

// File: rtl/pq_pkg.sv
package pq_pkg;
   typedef enum logic [1:0] {
      QS_IDLE  = 2'b00,
      QS_FIRST = 2'b01,
      QS_FLUSH = 2'b10,
      QS_NEXT  = 2'b11
   } qstat_t;
endpackage

// File: rtl/pq_storage.sv
module pq_storage #(
   parameter int DEPTH  = 6,
   parameter int BYTE_W = 8,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic [1:0]        push_cnt,
   input  logic [BYTE_W-1:0] push_b0,
   input  logic [BYTE_W-1:0] push_b1,
   input  logic              pop,
   output logic [CW-1:0]     count,
   output logic [BYTE_W-1:0] head
);
   logic [BYTE_W-1:0] mem [DEPTH];
   logic [PW-1:0]     wr_ptr, rd_ptr, wr1;
   logic              pop_ok;

   function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
   endfunction

   assign wr1    = step(wr_ptr);
   assign pop_ok = pop && (count != '0);
   assign head   = mem[rd_ptr];

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!clear && push_cnt != 2'd0 && wr_ptr == PW'(i))
            mem[i] <= push_b0;
         else if (!clear && push_cnt == 2'd2 && wr1 == PW'(i))
            mem[i] <= push_b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clear) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_cnt == 2'd1) wr_ptr <= wr1;
         else if (push_cnt == 2'd2) wr_ptr <= step(wr1);
         if (pop_ok) rd_ptr <= step(rd_ptr);
         count <= count + CW'(push_cnt) - CW'(pop_ok);
      end
   end

   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   assert_pop_shrinks_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && count != '0 && !clear && push_cnt == 2'd0) |=> count == CW'($past(count) - CW'(1)));
endmodule

// File: rtl/pq_fetch_ptr.sv
module pq_fetch_ptr #(
   parameter int                OFS_W     = 16,
   parameter logic [OFS_W-1:0]  RESET_OFS = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [OFS_W-1:0] flush_ofs,
   input  logic             accept,
   output logic [OFS_W-1:0] ofs,
   output logic             odd
);
   assign odd = ofs[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ofs <= RESET_OFS;
      else if (flush)  ofs <= flush_ofs;
      else if (accept) ofs <= ofs + (odd ? OFS_W'(1) : OFS_W'(2));
   end

   assert_ofs_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !flush) |=> ofs == $past(ofs) + ($past(odd) ? OFS_W'(1) : OFS_W'(2)));
   assert_flush_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> ofs == $past(flush_ofs));
endmodule

// File: rtl/pq_status.sv
module pq_status
   import pq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   flush,
   input  logic   pop,
   input  logic   pop_first,
   input  logic   empty,
   output qstat_t qstat,
   output logic   underflow
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qstat     <= QS_IDLE;
         underflow <= 1'b0;
      end else begin
         underflow <= !flush && pop && empty;
         if (flush)               qstat <= QS_FLUSH;
         else if (pop && !empty)  qstat <= pop_first ? QS_FIRST : QS_NEXT;
         else                     qstat <= QS_IDLE;
      end
   end

   assert_flush_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> qstat == QS_FLUSH);
   assert_uflow_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> qstat == QS_IDLE);
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
   import pq_pkg::*;
#(
   parameter int               DEPTH     = 6,
   parameter int               BYTE_W    = 8,
   parameter int               OFS_W     = 16,
   parameter logic [OFS_W-1:0] RESET_OFS = '0,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_valid,
   input  logic [2*BYTE_W-1:0] fill_data,
   output logic              fetch_req,
   output logic [OFS_W-1:0]  fetch_ofs,
   input  logic              pop,
   input  logic              pop_first,
   output logic              head_valid,
   output logic [BYTE_W-1:0] head_byte,
   input  logic              flush,
   input  logic [OFS_W-1:0]  flush_ofs,
   output logic [1:0]        qstat,
   output logic              underflow
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("prefetch_queue: DEPTH must be at least 2");
   end
   if (OFS_W < 2) begin : g_bad_ofs
      $error("prefetch_queue: OFS_W must be at least 2");
   end

   logic [CW-1:0] count, free;
   logic          odd, accept;
   logic [1:0]    push_cnt;
   qstat_t        qs;

   assign free       = CW'(DEPTH) - count;
   assign fetch_req  = (free >= CW'(2)) || (free >= CW'(1) && odd);
   assign accept     = fill_valid && fetch_req && !flush;
   assign push_cnt   = !accept ? 2'd0 : (odd ? 2'd1 : 2'd2);
   assign head_valid = (count != '0);
   assign qstat      = qs;

   pq_storage #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (flush),
      .push_cnt (push_cnt),
      .push_b0  (odd ? fill_data[2*BYTE_W-1:BYTE_W] : fill_data[BYTE_W-1:0]),
      .push_b1  (fill_data[2*BYTE_W-1:BYTE_W]),
      .pop      (pop),
      .count    (count),
      .head     (head_byte)
   );

   pq_fetch_ptr #(.OFS_W(OFS_W), .RESET_OFS(RESET_OFS)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .flush_ofs (flush_ofs),
      .accept    (accept),
      .ofs       (fetch_ofs),
      .odd       (odd)
   );

   pq_status u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .pop       (pop),
      .pop_first (pop_first),
      .empty     (!head_valid),
      .qstat     (qs),
      .underflow (underflow)
   );

   assert_fill_granted_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> fetch_req);
   assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !head_valid);
   assert_uflow_keeps_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !head_valid && !fill_valid && !flush) |=> !head_valid && underflow);
endmodule

// File: tb/test_prefetch_queue.sv
`timescale 1ns/1ps
module test_prefetch_queue;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fill_valid = 1'b0;
   logic [15:0] fill_data = '0;
   logic        fetch_req;
   logic [15:0] fetch_ofs;
   logic        pop = 1'b0, pop_first = 1'b0;
   logic        head_valid;
   logic [7:0]  head_byte;
   logic        flush = 1'b0;
   logic [15:0] flush_ofs = '0;
   logic [1:0]  qstat;
   logic        underflow;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [7:0]  mq[$];
   logic [15:0] mofs;
   int          mst;
   bit          muf;

   always #5 clk = ~clk;

   prefetch_queue i_prefetch_queue (
      .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_data(fill_data),
      .fetch_req(fetch_req), .fetch_ofs(fetch_ofs), .pop(pop), .pop_first(pop_first),
      .head_valid(head_valid), .head_byte(head_byte), .flush(flush), .flush_ofs(flush_ofs),
      .qstat(qstat), .underflow(underflow));

   function automatic logic [7:0] bv(input logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
   endfunction

   function automatic bit mreq();
      int fr = 6 - mq.size();
      return (fr >= 2) || (fr >= 1 && mofs[0]);
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, "head_valid", int'(head_valid), int'(mq.size() > 0));
      if (mq.size() > 0) chk(tag, "head_byte", int'(head_byte), int'(mq[0]));
      chk("R2", "fetch_req", int'(fetch_req), int'(mreq()));
      chk("R3", "fetch_ofs", int'(fetch_ofs), int'(mofs));
      chk(mst == 2 ? "R5" : "R4", "qstat", int'(qstat), mst);
      chk("R6", "underflow", int'(underflow), int'(muf));
   endtask

   // one cycle: drive at negedge, update model at posedge, check at next negedge
   task automatic cyc(input bit want_fill, input bit p, input bit pf,
                      input bit fl, input logic [15:0] fo, input string tag);
      bit do_fill = want_fill && mreq();
      fill_valid = do_fill;
      fill_data  = mofs[0] ? {bv(mofs), 8'hEE} : {bv(mofs + 16'd1), bv(mofs)};
      pop = p; pop_first = pf; flush = fl; flush_ofs = fo;
      @(posedge clk);
      if (fl) begin
         mq.delete(); mofs = fo; mst = 2; muf = 0;
      end else begin
         if (p && mq.size() > 0) begin
            void'(mq.pop_front()); mst = pf ? 1 : 3; muf = 0;
         end else begin
            mst = 0; muf = p;
         end
         if (do_fill) begin
            if (mofs[0]) begin mq.push_back(bv(mofs)); mofs = mofs + 16'd1; end
            else begin
               mq.push_back(bv(mofs)); mq.push_back(bv(mofs + 16'd1)); mofs = mofs + 16'd2;
            end
         end
      end
      @(negedge clk);
      fill_valid = 0; pop = 0; flush = 0;
      check_all(tag);
   endtask

   initial begin
      mofs = 16'h0000; mst = 0; muf = 0;
      repeat (3) @(negedge clk);
      // R8: reset state
      check_all("R8");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R8");

      // R2/R3: fill from each starting alignment until full, then drain (R1, R4), then empty pops (R6)
      for (int s = 0; s < 8; s++) begin
         cyc(0, 0, 0, 1, 16'h1230 + 16'(s * 7), "R5");
         for (int k = 0; k < 6; k++) cyc(1, 0, 0, 0, '0, "R3");
         for (int k = 0; k < 7; k++) cyc(0, 1, (k % 3) == 0, 0, '0, "R1");
         cyc(0, 1, 1, 0, '0, "R6");
         cyc(0, 0, 0, 0, '0, "R6");
      end

      // R7: fill and pop in the same cycles over many patterns
      for (int i = 0; i < 400; i++)
         cyc((i % 5) != 4, (i % 3) != 0 || (i % 7) == 0, (i % 4) == 0, 0, '0, "R7");

      // R5: flush overrides fill and pop in the same cycle
      for (int k = 0; k < 4; k++) cyc(1, 0, 0, 0, '0, "R5");
      cyc(1, 1, 1, 1, 16'h7FF1, "R5");
      cyc(0, 1, 0, 1, 16'hFFFE, "R5");
      for (int k = 0; k < 5; k++) cyc(1, 1, k == 0, 0, '0, "R1");
      for (int k = 0; k < 8; k++) cyc(0, 1, 0, 0, '0, "R6");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule